// File: doc/BRIEF.md
# Dual-Loop Lock Detector

This block judges whether two phase-locked loops, a main loop and an auxiliary loop, are in lock and reduces their verdicts to one registered lock indication. Each loop's phase detector supplies an up pulse and a down pulse, and each loop has a power-down flag. All inputs are sampled on the reference clock. A loop passes a comparison in a reference cycle when its phase error pulse is shorter than the error limit. A loop counts as locked once it has passed a run of consecutive comparisons.

The combined output follows the loops that are powered up. When both loops run, both must be locked. When one loop is powered down, the other loop alone decides. When both loops are powered down, the output reads out of lock. A loop that leaves power-down starts from the unlocked state and has to qualify again.

Top module: `dual_lock_detect`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `lock` is 0.
- R2: In each reference cycle, a powered-up loop measures its error pulse width. This width is the number of consecutive sampled cycles in which its up or down input is 1. The comparison fails when the width reaches `ERR_LIMIT` cycles. With the default of 1, every cycle in which up or down is sampled high is a failing comparison, and a pulse that lasts several cycles keeps that loop unlocked.
- R3: A loop's lock flag is set by the clock edge that completes `QUAL_CNT` consecutive passing comparisons (default 4). `lock` reflects the flags one clock later. After a quiet start with both loops up, `lock` is 0 after 4 edges and 1 after 5.
- R4: One failing comparison clears that loop's flag at the same edge, and the qualification run starts again from zero.
- R5: With both power-down inputs at 0, `lock` becomes the AND of the two loop flags at the following edge.
- R6: With exactly one power-down input at 1, `lock` becomes the other loop's flag at the following edge. The powered-down loop's up and down inputs have no effect.
- R7: With both power-down inputs at 1, `lock` becomes 0 at the following edge, whatever the other inputs are.
- R8: A loop's flag is 0 while it is powered down and in the cycle it leaves power-down. It needs a full qualification run again before it can be set.
- R9: Up and down both high in the same cycle count as a single active error cycle, which is a failing comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_up | input | 1 | Main loop phase detector up pulse |
| main_dn | input | 1 | Main loop phase detector down pulse |
| main_pd | input | 1 | Main loop power-down, 1 = powered down |
| aux_up | input | 1 | Auxiliary loop phase detector up pulse |
| aux_dn | input | 1 | Auxiliary loop phase detector down pulse |
| aux_pd | input | 1 | Auxiliary loop power-down, 1 = powered down |
| lock | output | 1 | Registered combined lock indication |

## Verification
The bench first holds both loops quiet. This checks the exact edge on which qualification completes, and so separates an off-by-one qualification count from a correct one. Single-cycle error pulses on one loop, and pulses with up and down together, show whether one failure clears a flag and whether the two pulse inputs are merged. Noise on a powered-down loop while the other loop is quiet, and each power-down combination, separate the AND rule from the single-loop and forced-zero rules. Leaving power-down and a long pseudo-random pulse stream then test requalification and the width measurement against a behavioural model.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  // Saturating increment used by both the width meter and the qualifier.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Combined lock rule over the two loops.
  function automatic logic lock_combine(input logic m_flag, input logic a_flag,
                                        input logic m_pd, input logic a_pd);
    logic r;
    unique case ({m_pd, a_pd})
      2'b00:   r = m_flag & a_flag;
      2'b01:   r = m_flag;
      2'b10:   r = a_flag;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lkd_width_meter.sv
module lkd_width_meter #(
  parameter int unsigned ERR_LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic up,
  input  logic dn,
  output logic fail
);
  import lkd_pkg::*;

  localparam int RUN_W = $clog2(ERR_LIMIT + 1);

  logic [RUN_W-1:0] run_q;
  logic             active;
  int unsigned      run_nxt;

  always_comb begin
    active  = up | dn;
    run_nxt = active ? sat_inc(int'(run_q), ERR_LIMIT) : 0;
    fail    = !pd && active && (run_nxt >= ERR_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  run_q <= '0;
    else if (pd) run_q <= '0;
    else         run_q <= RUN_W'(run_nxt);
  end

endmodule

// File: rtl/lkd_qualifier.sv
module lkd_qualifier #(
  parameter int unsigned QUAL_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic fail,
  output logic flag
);
  import lkd_pkg::*;

  localparam int CNT_W = $clog2(QUAL_CNT + 1);

  logic [CNT_W-1:0] pass_q;
  int unsigned      pass_nxt;

  always_comb pass_nxt = fail ? 0 : sat_inc(int'(pass_q), QUAL_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= '0;
      flag   <= 1'b0;
    end else if (pd) begin
      pass_q <= '0;
      flag   <= 1'b0;
    end else begin
      pass_q <= CNT_W'(pass_nxt);
      flag   <= (pass_nxt == QUAL_CNT);
    end
  end

endmodule

// File: rtl/lkd_loop_monitor.sv
module lkd_loop_monitor #(
  parameter int unsigned ERR_LIMIT = 1,
  parameter int unsigned QUAL_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic up,
  input  logic dn,
  output logic fail,
  output logic flag
);

  lkd_width_meter #(.ERR_LIMIT(ERR_LIMIT)) u_meter (
    .clk(clk), .rst_n(rst_n), .pd(pd), .up(up), .dn(dn), .fail(fail)
  );

  lkd_qualifier #(.QUAL_CNT(QUAL_CNT)) u_qual (
    .clk(clk), .rst_n(rst_n), .pd(pd), .fail(fail), .flag(flag)
  );

endmodule

// File: rtl/lkd_combiner.sv
module lkd_combiner (
  input  logic clk,
  input  logic rst_n,
  input  logic m_flag,
  input  logic a_flag,
  input  logic m_pd,
  input  logic a_pd,
  output logic lock
);
  import lkd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock <= 1'b0;
    else        lock <= lock_combine(m_flag, a_flag, m_pd, a_pd);
  end

endmodule

// File: rtl/dual_lock_detect.sv
module dual_lock_detect #(
  parameter int unsigned ERR_LIMIT = 1,
  parameter int unsigned QUAL_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_up,
  input  logic main_dn,
  input  logic main_pd,
  input  logic aux_up,
  input  logic aux_dn,
  input  logic aux_pd,
  output logic lock
);

  localparam int NLOOP = 2;

  logic [NLOOP-1:0] up_v, dn_v, pd_v, fail_v, flag_v;

  assign up_v = {aux_up, main_up};
  assign dn_v = {aux_dn, main_dn};
  assign pd_v = {aux_pd, main_pd};

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    lkd_loop_monitor #(.ERR_LIMIT(ERR_LIMIT), .QUAL_CNT(QUAL_CNT)) u_mon (
      .clk(clk), .rst_n(rst_n), .pd(pd_v[g]), .up(up_v[g]), .dn(dn_v[g]),
      .fail(fail_v[g]), .flag(flag_v[g])
    );
  end

  // Named internal events for the checker.
  logic main_fail, aux_fail, main_flag, aux_flag;
  assign main_fail = fail_v[0];
  assign aux_fail  = fail_v[1];
  assign main_flag = flag_v[0];
  assign aux_flag  = flag_v[1];

  lkd_combiner u_comb (
    .clk(clk), .rst_n(rst_n), .m_flag(main_flag), .a_flag(aux_flag),
    .m_pd(main_pd), .a_pd(aux_pd), .lock(lock)
  );

endmodule

// File: rtl/lkd_checks.sv
module lkd_checks #(
  parameter int unsigned QUAL_CNT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic main_pd,
  input logic aux_pd,
  input logic main_fail,
  input logic aux_fail,
  input logic main_flag,
  input logic aux_flag,
  input logic lock
);

  int unsigned main_run, aux_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_run <= 0;
      aux_run  <= 0;
    end else begin
      main_run <= (main_pd || main_fail) ? 0 : ((main_run >= QUAL_CNT) ? QUAL_CNT : main_run + 1);
      aux_run  <= (aux_pd  || aux_fail)  ? 0 : ((aux_run  >= QUAL_CNT) ? QUAL_CNT : aux_run + 1);
    end
  end

  always_comb if (!rst_n) a_r1_reset_low: assert (lock == 1'b0);

  a_r3_main_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    main_flag |-> main_run >= QUAL_CNT);
  a_r3_aux_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    aux_flag |-> aux_run >= QUAL_CNT);
  a_r4_main_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    main_fail |=> !main_flag);
  a_r4_aux_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    aux_fail |=> !aux_flag);
  a_r5_both_up_and: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_pd && !aux_pd) |=> lock == ($past(main_flag) && $past(aux_flag)));
  a_r6_aux_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pd && !aux_pd) |=> lock == $past(aux_flag));
  a_r6_main_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_pd && aux_pd) |=> lock == $past(main_flag));
  a_r7_both_down: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pd && aux_pd) |=> !lock);
  a_r8_main_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_pd) |-> !main_flag);
  a_r8_aux_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_pd) |-> !aux_flag);

endmodule

bind dual_lock_detect lkd_checks #(.QUAL_CNT(QUAL_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_pd(main_pd), .aux_pd(aux_pd),
  .main_fail(main_fail), .aux_fail(aux_fail),
  .main_flag(main_flag), .aux_flag(aux_flag), .lock(lock)
);

// File: tb/tb_dual_lock_detect.sv
module tb_dual_lock_detect;

  localparam int LIM  = 1;
  localparam int QUAL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_up = 0, main_dn = 0, main_pd = 0;
  logic aux_up = 0, aux_dn = 0, aux_pd = 0;
  logic lock;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  dual_lock_detect #(.ERR_LIMIT(LIM), .QUAL_CNT(QUAL)) dut (
    .clk(clk), .rst_n(rst_n), .main_up(main_up), .main_dn(main_dn), .main_pd(main_pd),
    .aux_up(aux_up), .aux_dn(aux_dn), .aux_pd(aux_pd), .lock(lock)
  );

  always #5 clk = ~clk;

  // Behavioural model: per loop error run, pass run and flag, as integers.
  int  m_err = 0, a_err = 0, m_pass = 0, a_pass = 0;
  bit  m_ok = 0, a_ok = 0, exp_lock = 0;

  task automatic model_loop(input bit pd, input bit act, ref int err, ref int pass, ref bit ok);
    if (pd) begin
      err = 0; pass = 0; ok = 0;
    end else begin
      err = act ? err + 1 : 0;
      if (err >= LIM) pass = 0;
      else if (pass < QUAL) pass = pass + 1;
      ok = (pass >= QUAL);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = 0; a_err = 0; m_pass = 0; a_pass = 0; m_ok = 0; a_ok = 0; exp_lock = 0;
    end else begin
      if (main_pd && aux_pd)  exp_lock = 0;
      else if (main_pd)       exp_lock = a_ok;
      else if (aux_pd)        exp_lock = m_ok;
      else                    exp_lock = m_ok && a_ok;
      model_loop(main_pd, main_up || main_dn, m_err, m_pass, m_ok);
      model_loop(aux_pd, aux_up || aux_dn, a_err, a_pass, a_ok);
    end
  end

  task automatic check(input string t, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lock=%0b expected=%0b at cycle %0d", t, act, exp, cycles);
    end
  endtask

  // Compare with the model on every clock, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) check(tag, lock, exp_lock);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    step(20000);
    fails++;
    $display("FAIL watchdog: lock=%0b expected=finish", lock);
    finish_run();
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    // R1: reset
    step(3);
    check("R1 in reset", lock, 1'b0);
    rst_n = 1'b1;
    step(1); check("R1 first cycle", lock, 1'b0);
    // R3: qualification timing with both loops quiet
    tag = "R3";
    step(3); check("R3 after 4 edges", lock, 1'b0);
    step(1); check("R3 after 5 edges", lock, 1'b1);
    // R4 / R2: one-cycle main error pulse
    tag = "R4";
    main_up = 1; step(1); check("R4 same edge", lock, 1'b1);
    main_up = 0; step(1); check("R4 drop", lock, 1'b0);
    step(10); check("R4 recovered", lock, 1'b1);
    // R2: multi-cycle pulse keeps lock low
    tag = "R2";
    main_dn = 1; step(3); main_dn = 0; step(1); check("R2 long pulse", lock, 1'b0);
    step(10);
    // R9: up and down together
    tag = "R9";
    aux_up = 1; aux_dn = 1; step(1); aux_up = 0; aux_dn = 0; step(1);
    check("R9 both pulses", lock, 1'b0);
    step(10);
    // R5: aux noisy every 3 cycles while main is quiet
    tag = "R5";
    for (int i = 0; i < 8; i++) begin aux_up = 1; step(1); aux_up = 0; step(2); end
    check("R5 AND rule", lock, 1'b0);
    step(10); check("R5 both locked", lock, 1'b1);
    // R6: aux powered down and noisy, main alone decides
    tag = "R6";
    aux_pd = 1;
    for (int i = 0; i < 6; i++) begin aux_up = ~aux_up; aux_dn = aux_up; step(1); end
    aux_up = 0; aux_dn = 0;
    check("R6 main alone", lock, 1'b1);
    main_up = 1; step(1); main_up = 0; step(1); check("R6 main fail", lock, 1'b0);
    step(10);
    main_pd = 1; aux_pd = 0; step(12); check("R6 aux alone", lock, 1'b1);
    // R7: both powered down
    tag = "R7";
    aux_pd = 1; step(2); check("R7 both down", lock, 1'b0);
    step(8); check("R7 held", lock, 1'b0);
    // R8: leaving power-down requalifies
    tag = "R8";
    main_pd = 0; aux_pd = 0;
    step(4); check("R8 after 4 edges", lock, 1'b0);
    step(1); check("R8 after 5 edges", lock, 1'b1);
    aux_pd = 1; step(3); aux_pd = 0; step(2); check("R8 aux wake", lock, 1'b0);
    step(10);
    // Pseudo-random pulses and power-down changes against the model
    tag = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      main_up = (lfsr[3:0] == 4'h0);
      main_dn = (lfsr[7:4] == 4'h5);
      aux_up  = (lfsr[11:8] == 4'h9);
      aux_dn  = (lfsr[15:12] == 4'h3);
      if (lfsr[9:0] == 10'h0AB) main_pd = ~main_pd;
      if (lfsr[9:0] == 10'h155) aux_pd = ~aux_pd;
      step(1);
    end
    finish_run();
  end

endmodule